// File: doc/BRIEF.md
# Floating-Point Register Status and Rename Table

This block keeps the status of a small floating-point register file for an out-of-order issue stage. Each register holds a data word, a busy flag and a producer tag. When an operation issues, the block answers two source lookups: a register that holds its value returns that value with tag 0, and a register that is waiting returns the tag of the unit that will produce its value. In the same cycle the destination register is renamed to the tag of the issuing station.

The block also watches the result broadcast bus. A waiting register takes a broadcast value only when the broadcast tag equals its current tag. Results from older producers of a register that has since been renamed are therefore dropped. A broadcast is applied before an issue in the same cycle, so lookups in that cycle already see the broadcast value. A rename in that cycle still takes priority over the clear.

Top module: `fp_reg_status`

## Requirements
- R1: After reset every register is not busy and holds data 0, so every lookup returns data 0 with tag 0.
- R2: A lookup of a register that is not busy returns its stored data with tag 0.
- R3: A lookup of a busy register returns its producer tag, which is nonzero.
- R4: An issue with `iss_valid` high sets the destination busy with `iss_tag` from the next cycle on, replacing any earlier pending tag.
- R5: A lookup of a register that is renamed in the same cycle returns the value held before the rename.
- R6: A broadcast whose tag equals a busy register's tag writes `bc_data` into it and clears busy from the next cycle on.
- R7: A broadcast whose tag differs from a busy register's current tag leaves that register's busy flag, tag and data unchanged.
- R8: When a matching broadcast and a rename hit the same register in one cycle, the register stays busy and takes the new tag.
- R9: A lookup in the same cycle as a broadcast that matches the looked-up busy register returns `bc_data` with tag 0.
- R10: One broadcast updates every register that waits on its tag.
- R11: With `iss_valid` low, no register is renamed, whatever the other issue inputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue this cycle; renames `iss_dst` |
| iss_dst | input | IDXW | Destination register index |
| iss_tag | input | TAGW | Tag of the issuing station (nonzero) |
| src_a_idx | input | IDXW | First source register index |
| src_b_idx | input | IDXW | Second source register index |
| src_a_data | output | DW | First source value, meaningful when tag is 0 |
| src_a_tag | output | TAGW | First source producer tag, 0 when the value is present |
| src_b_data | output | DW | Second source value, meaningful when tag is 0 |
| src_b_tag | output | TAGW | Second source producer tag, 0 when the value is present |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAGW | Tag of the broadcasting producer |
| bc_data | input | DW | Broadcast result value |

## Verification
The bench targets the cases where ordering inside a single cycle matters. It reads a register while renaming it; a design that updated first would return the new tag instead of the old value. It broadcasts a stale tag to a register that was renamed twice; a design without the tag compare would mark the register valid with an outdated result. It also broadcasts and renames the same register in one cycle. If the clear won, the register would lose its new pending tag. If the broadcast were not forwarded, a same-cycle lookup would return a tag that is already retired.

// File: rtl/fp_reg_status.sv
module fp_reg_status #(
  parameter int NREG = 4,
  parameter int TAGW = 4,
  parameter int DW   = 32,
  parameter int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_valid,
  input  logic [IDXW-1:0] iss_dst,
  input  logic [TAGW-1:0] iss_tag,
  input  logic [IDXW-1:0] src_a_idx,
  input  logic [IDXW-1:0] src_b_idx,
  output logic [DW-1:0]   src_a_data,
  output logic [TAGW-1:0] src_a_tag,
  output logic [DW-1:0]   src_b_data,
  output logic [TAGW-1:0] src_b_tag,
  input  logic            bc_valid,
  input  logic [TAGW-1:0] bc_tag,
  input  logic [DW-1:0]   bc_data
);

  logic [NREG-1:0]           busy_q;
  logic [NREG-1:0][TAGW-1:0] tag_q;
  logic [NREG-1:0][DW-1:0]   data_q;
  logic [NREG-1:0]           hit;
  logic [NREG-1:0]           ren;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    assign hit[r] = bc_valid && busy_q[r] && (tag_q[r] == bc_tag);
    assign ren[r] = iss_valid && (iss_dst == IDXW'(r));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_q[r] <= 1'b0;
        tag_q[r]  <= '0;
        data_q[r] <= '0;
      end else begin
        if (hit[r]) data_q[r] <= bc_data;
        if (ren[r]) begin
          busy_q[r] <= 1'b1;
          tag_q[r]  <= iss_tag;
        end else if (hit[r]) begin
          busy_q[r] <= 1'b0;
          tag_q[r]  <= '0;
        end
      end
    end
  end

  assign src_a_data = hit[src_a_idx] ? bc_data : data_q[src_a_idx];
  assign src_a_tag  = (busy_q[src_a_idx] && !hit[src_a_idx]) ? tag_q[src_a_idx] : '0;
  assign src_b_data = hit[src_b_idx] ? bc_data : data_q[src_b_idx];
  assign src_b_tag  = (busy_q[src_b_idx] && !hit[src_b_idx]) ? tag_q[src_b_idx] : '0;

endmodule

module fp_reg_status_chk #(
  parameter int NREG = 4,
  parameter int TAGW = 4,
  parameter int DW   = 32,
  parameter int IDXW = $clog2(NREG)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      iss_valid,
  input logic [IDXW-1:0]           iss_dst,
  input logic [TAGW-1:0]           iss_tag,
  input logic [IDXW-1:0]           src_a_idx,
  input logic [TAGW-1:0]           src_a_tag,
  input logic                      bc_valid,
  input logic [TAGW-1:0]           bc_tag,
  input logic [DW-1:0]             bc_data,
  input logic [NREG-1:0]           busy_q,
  input logic [NREG-1:0][TAGW-1:0] tag_q,
  input logic [NREG-1:0][DW-1:0]   data_q
);

  AST_BUSY_TAG_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a_tag != '0) |-> busy_q[src_a_idx]); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!iss_valid && !bc_valid) |=> ($stable(busy_q) && $stable(tag_q) && $stable(data_q))); // R11

  for (genvar r = 0; r < NREG; r++) begin : g_chk
    AST_RENAME_TAKES_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_dst == IDXW'(r)) |=> (busy_q[r] && tag_q[r] == $past(iss_tag))); // R4

    AST_STALE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_valid && busy_q[r] && bc_tag != tag_q[r] && !(iss_valid && iss_dst == IDXW'(r)))
      |=> (busy_q[r] && $stable(tag_q[r]) && $stable(data_q[r]))); // R7

    AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_valid && busy_q[r] && bc_tag == tag_q[r] && !(iss_valid && iss_dst == IDXW'(r)))
      |=> (!busy_q[r] && data_q[r] == $past(bc_data))); // R6
  end

endmodule

bind fp_reg_status fp_reg_status_chk #(.NREG(NREG), .TAGW(TAGW), .DW(DW), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_tag(iss_tag),
  .src_a_idx(src_a_idx), .src_a_tag(src_a_tag), .bc_valid(bc_valid), .bc_tag(bc_tag),
  .bc_data(bc_data), .busy_q(busy_q), .tag_q(tag_q), .data_q(data_q)
);

// File: tb/fp_reg_status_bench.sv
module fp_reg_status_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic [1:0]  iss_dst = '0;
  logic [3:0]  iss_tag = '0;
  logic [1:0]  src_a_idx = '0;
  logic [1:0]  src_b_idx = '0;
  logic [31:0] src_a_data, src_b_data;
  logic [3:0]  src_a_tag, src_b_tag;
  logic        bc_valid = 1'b0;
  logic [3:0]  bc_tag = '0;
  logic [31:0] bc_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fp_reg_status u_fp_reg_status (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .src_a_idx(src_a_idx), .src_b_idx(src_b_idx), .src_a_data(src_a_data), .src_a_tag(src_a_tag),
    .src_b_data(src_b_data), .src_b_tag(src_b_tag), .bc_valid(bc_valid), .bc_tag(bc_tag),
    .bc_data(bc_data)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive at negedge, settle, caller checks, then wait for the commit edge
  task automatic drive(bit iv, int dst, int itag, int sa, int sb, bit bv, int btag, int bdata);
    @(negedge clk);
    iss_valid = iv; iss_dst = 2'(dst); iss_tag = 4'(itag);
    src_a_idx = 2'(sa); src_b_idx = 2'(sb);
    bc_valid = bv; bc_tag = 4'(btag); bc_data = 32'(bdata);
    #1;
  endtask

  task automatic lookup(string req, int r, int exp_data, int exp_tag);
    drive(0, 0, 0, r, r, 0, 0, 0);
    if (exp_tag == 0) chk(req, src_a_data, 32'(exp_data));
    chk(req, {28'd0, src_a_tag}, 32'(exp_tag));
  endtask

  task automatic t_reset;
    for (int r = 0; r < 4; r++) begin
      drive(0, 0, 0, r, r, 0, 0, 0);
      chk("R1", src_a_data, 0); chk("R1", {28'd0, src_b_tag}, 0);
    end
  endtask

  task automatic t_rename_then_broadcast;
    drive(1, 0, 4, 0, 1, 0, 0, 0);
    chk("R5", src_a_data, 0); chk("R5", {28'd0, src_a_tag}, 0);
    lookup("R3 R4", 0, 0, 4);
    drive(0, 0, 0, 2, 0, 1, 4, 32'hA5A5);
    chk("R9", src_b_data, 32'hA5A5); chk("R9", {28'd0, src_b_tag}, 0);
    lookup("R6 R2", 0, 32'hA5A5, 0);
  endtask

  task automatic t_stale_waw;
    drive(1, 1, 10, 0, 0, 0, 0, 0);
    drive(1, 1, 11, 1, 1, 0, 0, 0);
    chk("R3", {28'd0, src_a_tag}, 10);
    lookup("R4", 1, 0, 11);
    drive(0, 0, 0, 1, 1, 1, 10, 32'h111);
    chk("R7", {28'd0, src_a_tag}, 11);
    lookup("R7", 1, 0, 11);
    drive(0, 0, 0, 0, 0, 1, 11, 32'h222);
    lookup("R6", 1, 32'h222, 0);
  endtask

  task automatic t_same_cycle_race;
    drive(1, 2, 12, 0, 0, 0, 0, 0);
    drive(1, 2, 8, 2, 2, 1, 12, 32'h333);
    chk("R9 R5", src_a_data, 32'h333); chk("R9 R5", {28'd0, src_a_tag}, 0);
    lookup("R8", 2, 0, 8);
    drive(0, 0, 0, 0, 0, 1, 8, 32'h444);
    lookup("R8", 2, 32'h444, 0);
  endtask

  task automatic t_fanout_and_gate;
    drive(1, 0, 5, 0, 0, 0, 0, 0);
    drive(1, 3, 5, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 1, 5, 32'h55);
    lookup("R10", 0, 32'h55, 0);
    lookup("R10", 3, 32'h55, 0);
    drive(0, 3, 9, 0, 0, 0, 0, 0);
    lookup("R11", 3, 32'h55, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_rename_then_broadcast();
    t_stale_waw();
    t_same_cycle_race();
    t_fanout_and_gate();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule